// File: doc/BRIEF.md
# Trace Capture Status and Trigger Tracker

This block keeps the status flags of a trace capture buffer controller and presents them as a single 32-bit read-only status word. It watches the capture state (off, running, stopping), the trigger pin, the trace ID stream, memory write strobes and a set of idle and occupancy indications. From these it derives five flags: the buffer-empty flag, the formatter-idle flag, the overall ready flag, the triggered flag and the buffer-full flag.

The triggered flag is set by either of two events while capture runs. The first is a reserved trace ID arriving on the input stream. The second is a programmable number of memory word writes after a rising edge on the trigger pin. Four flags (ready, formatter-idle, triggered, full) are cleared when the controller moves out of the off state, and they keep their value while it is off. The surrounding controller decodes the status word for register reads. The word has no write path, so a write to it changes nothing.

Top module: `trace_status_tracker`

## Requirements
- R1: The status word carries Empty in bit 4, FtEmpty in bit 3, Ready in bit 2, Triggered in bit 1 and Full in bit 0. Bits [31:5] always read 0.
- R2: While reset is asserted the status word reads 0x00000004, with Ready = 1 and every other bit 0.
- R3: In a non-off cycle that is not the exit cycle, Ready is loaded at the clock edge. It is loaded with 1 only when all of these hold: capState is stopping (code 2 or 3), pipeDrained = 1, drainActive = 0, busIdle = 1 and writeRespDone = 1. Otherwise it is loaded with 0.
- R4: FtEmpty is loaded the same way as Ready, but only stopping and pipeDrained matter. It ignores drainActive, busIdle and writeRespDone.
- R5: The first cycle with capState != 0 after a cycle with capState = 0 is the exit cycle. After the exit cycle's clock edge, bits [3:0] read 0.
- R6: After any cycle with capState = 0 (off), bits [3:0] keep the value they had before that cycle.
- R7: In a capturing cycle (capState = 1, not the exit cycle), traceValid = 1 with traceId = 0x7D sets Triggered at that cycle's edge.
- R8: A trigger-pin rising edge in a capturing cycle arms a countdown loaded from postTrigCount. Each later capturing cycle with memWordWr = 1 decrements the count. In the capturing cycle after the count reads zero, Triggered is set. A count of 0 therefore sets Triggered at the edge of the cycle after the rising edge.
- R9: While the countdown is armed, further rising edges on the trigger pin do not reload the count.
- R10: Triggered never sets outside a capturing cycle, and once set it stays set until the next exit cycle.
- R11: Full becomes 1 when memFull = 1 is seen in a non-off cycle and then stays 1. While capState = 0, changes on memFull have no effect on it.
- R12: Empty shows the value of memEmpty from the previous cycle, in every capture state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| capState | input | 2 | Capture state: 0 off, 1 capturing, 2 or 3 stopping |
| trigIn | input | 1 | Trigger pin |
| traceId | input | ID_W | Trace ID of the incoming beat |
| traceValid | input | 1 | Incoming trace beat valid |
| memWordWr | input | 1 | A data word is written to trace memory this cycle |
| postTrigCount | input | CNT_W | Number of words to write after a pin trigger |
| pipeDrained | input | 1 | Internal pipelines and buffers are empty |
| drainActive | input | 1 | A buffer drain request is in progress |
| busIdle | input | 1 | Memory bus interface is idle |
| writeRespDone | input | 1 | Response to the last memory write has returned |
| memEmpty | input | 1 | Trace memory holds no valid data |
| memFull | input | 1 | Trace memory is full |
| statusWord | output | 32 | Status word |

## Verification
The embedded properties check on every cycle that Ready and FtEmpty only rise after a cycle that met their own idle conditions, and that Triggered only rises after a capturing cycle and only falls at an exit. They also check that every flag except Empty is cleared after an exit and frozen while the controller is off, and that an armed countdown is never reloaded upward. The bench scenarios are needed to show the exact trigger timing: the counting of words after a pin edge, the zero-count case, and that a second pin edge mid-count is ignored. The scenarios also show that the reserved ID is the only ID that triggers, that Full ignores memory changes while off, and the layout and reset value of the status word.

// File: rtl/trace_status_pkg.sv
package trace_status_pkg;

  typedef enum logic [1:0] {
    CAP_OFF      = 2'd0,
    CAP_RUN      = 2'd1,
    CAP_STOP     = 2'd2,
    CAP_STOP_ALT = 2'd3
  } capMode_t;

  // strobes from control to datapath, one cycle's worth of decisions
  typedef struct packed {
    logic clearFlags;  // exit from off state
    logic update;      // non-off, non-exit cycle: idle/full flags may change
    logic stopped;     // capture stopping (idle flags may be set)
    logic armLoad;     // load post-trigger countdown
    logic countDown;   // decrement countdown
    logic fire;        // set triggered
  } tstStrobes_t;

  localparam int STATUS_W = 32;

endpackage

// File: rtl/tst_control.sv
module tst_control
  import trace_status_pkg::*;
#(
  parameter int ID_W = 7,
  parameter logic [ID_W-1:0] TRIG_ID = 7'h7D
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      capState,
  input  logic            trigIn,
  input  logic [ID_W-1:0] traceId,
  input  logic            traceValid,
  input  logic            memWordWr,
  input  logic            armed,
  input  logic            cntZero,
  input  logic            triggered,
  output tstStrobes_t     strb
);

  capMode_t mode;
  logic wasOff, trigPrev;
  logic isOff, leaving, capturing, canTrig, pinRise, idHit;

  assign mode = capMode_t'(capState);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wasOff   <= 1'b1;
      trigPrev <= 1'b0;
    end else begin
      wasOff   <= (mode == CAP_OFF);
      trigPrev <= trigIn;
    end
  end

  always_comb begin
    isOff     = (mode == CAP_OFF);
    leaving   = wasOff && !isOff;
    capturing = (mode == CAP_RUN) && !leaving;
    canTrig   = capturing && !triggered;
    pinRise   = trigIn && !trigPrev;
    idHit     = traceValid && (traceId == TRIG_ID);

    strb.clearFlags = leaving;
    strb.update     = !isOff && !leaving;
    strb.stopped    = ((mode == CAP_STOP) || (mode == CAP_STOP_ALT)) && !leaving;
    strb.fire       = canTrig && (idHit || (armed && cntZero));
    strb.armLoad    = canTrig && !armed && pinRise && !idHit;
    strb.countDown  = canTrig && armed && !cntZero && memWordWr;
  end

endmodule

// File: rtl/tst_datapath.sv
module tst_datapath
  import trace_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tstStrobes_t      strb,
  input  logic [CNT_W-1:0] postTrigCount,
  input  logic             pipeDrained,
  input  logic             drainActive,
  input  logic             busIdle,
  input  logic             writeRespDone,
  input  logic             memEmpty,
  input  logic             memFull,
  output logic             emptyFlag,
  output logic             ftEmptyFlag,
  output logic             readyFlag,
  output logic             trigFlag,
  output logic             fullFlag,
  output logic             armed,
  output logic             cntZero
);

  logic [CNT_W-1:0] remaining;
  logic readyCond, ftCond;

  assign readyCond = strb.stopped && pipeDrained && !drainActive && busIdle && writeRespDone;
  assign ftCond    = strb.stopped && pipeDrained;
  assign cntZero   = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyFlag   <= 1'b0;
      ftEmptyFlag <= 1'b0;
      readyFlag   <= 1'b1;
      trigFlag    <= 1'b0;
      fullFlag    <= 1'b0;
      armed       <= 1'b0;
      remaining   <= '0;
    end else begin
      emptyFlag <= memEmpty;
      if (strb.clearFlags) begin
        ftEmptyFlag <= 1'b0;
        readyFlag   <= 1'b0;
        trigFlag    <= 1'b0;
        fullFlag    <= 1'b0;
        armed       <= 1'b0;
      end else begin
        if (strb.update) begin
          ftEmptyFlag <= ftCond;
          readyFlag   <= readyCond;
          fullFlag    <= fullFlag || memFull;
        end
        if (strb.fire) begin
          trigFlag <= 1'b1;
          armed    <= 1'b0;
        end else if (strb.armLoad) begin
          armed     <= 1'b1;
          remaining <= postTrigCount;
        end else if (strb.countDown) begin
          remaining <= remaining - 1'b1;
        end
      end
    end
  end

  // R10: triggered only drops at an exit from the off state
  assert_trig_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(trigFlag) |-> $past(strb.clearFlags));

  // R9: an armed countdown never moves upward (no reload)
  assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> (remaining <= $past(remaining)));

  // R6: nothing but Empty moves in an off cycle
  assert_hold_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clearFlags && !strb.update) |=>
      $stable({readyFlag, ftEmptyFlag, trigFlag, fullFlag}));

endmodule

// File: rtl/trace_status_tracker.sv
module trace_status_tracker
  import trace_status_pkg::*;
#(
  parameter int ID_W  = 7,
  parameter int CNT_W = 16,
  parameter logic [ID_W-1:0] TRIG_ID = 7'h7D
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          capState,
  input  logic                trigIn,
  input  logic [ID_W-1:0]     traceId,
  input  logic                traceValid,
  input  logic                memWordWr,
  input  logic [CNT_W-1:0]    postTrigCount,
  input  logic                pipeDrained,
  input  logic                drainActive,
  input  logic                busIdle,
  input  logic                writeRespDone,
  input  logic                memEmpty,
  input  logic                memFull,
  output logic [STATUS_W-1:0] statusWord
);

  tstStrobes_t strb;
  logic emptyFlag, ftEmptyFlag, readyFlag, trigFlag, fullFlag, armed, cntZero;

  tst_control #(.ID_W(ID_W), .TRIG_ID(TRIG_ID)) u_control (
    .clk(clk), .rstN(rstN), .capState(capState), .trigIn(trigIn),
    .traceId(traceId), .traceValid(traceValid), .memWordWr(memWordWr),
    .armed(armed), .cntZero(cntZero), .triggered(trigFlag), .strb(strb)
  );

  tst_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .postTrigCount(postTrigCount),
    .pipeDrained(pipeDrained), .drainActive(drainActive), .busIdle(busIdle),
    .writeRespDone(writeRespDone), .memEmpty(memEmpty), .memFull(memFull),
    .emptyFlag(emptyFlag), .ftEmptyFlag(ftEmptyFlag), .readyFlag(readyFlag),
    .trigFlag(trigFlag), .fullFlag(fullFlag), .armed(armed), .cntZero(cntZero)
  );

  assign statusWord = {{(STATUS_W-5){1'b0}}, emptyFlag, ftEmptyFlag, readyFlag, trigFlag, fullFlag};

  // R5: exit from off leaves the four state flags cleared
  assert_clear_on_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearFlags |=> (statusWord[3:0] == 4'b0000));

  // R3: Ready rises only after a fully idle stopping cycle
  assert_ready_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[2]) |->
      $past(capState[1] && pipeDrained && !drainActive && busIdle && writeRespDone));

  // R4: FtEmpty rises only after a drained stopping cycle
  assert_ftempty_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[3]) |-> $past(capState[1] && pipeDrained));

  // R7 / R10: Triggered rises only after a capturing cycle
  assert_trig_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[1]) |-> ($past(capState) == 2'd1));

endmodule

// File: tb/test_trace_status_tracker.sv
`timescale 1ns/1ps
module test_trace_status_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  capState = 2'd0;
  logic        trigIn = 1'b0;
  logic [6:0]  traceId = 7'd0;
  logic        traceValid = 1'b0;
  logic        memWordWr = 1'b0;
  logic [15:0] postTrigCount = 16'd3;
  logic        pipeDrained = 1'b1;
  logic        drainActive = 1'b0;
  logic        busIdle = 1'b1;
  logic        writeRespDone = 1'b1;
  logic        memEmpty = 1'b1;
  logic        memFull = 1'b0;
  logic [31:0] statusWord;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] qMask[$];
  logic [31:0] qVal[$];
  string       qTag[$];
  logic [31:0] curMask, curVal;
  string       curTag;

  always #2.5 clk = ~clk;

  trace_status_tracker i_trace_status_tracker (
    .clk(clk), .rstN(rstN), .capState(capState), .trigIn(trigIn),
    .traceId(traceId), .traceValid(traceValid), .memWordWr(memWordWr),
    .postTrigCount(postTrigCount), .pipeDrained(pipeDrained),
    .drainActive(drainActive), .busIdle(busIdle), .writeRespDone(writeRespDone),
    .memEmpty(memEmpty), .memFull(memFull), .statusWord(statusWord)
  );

  // driver: push the expected status after this cycle's edge, advance one cycle
  task automatic cyc(input logic [31:0] mask, input logic [31:0] val, input string tag);
    qMask.push_back(mask);
    qVal.push_back(val);
    qTag.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (qMask.size() > 0) begin
      curMask = qMask.pop_front();
      curVal  = qVal.pop_front();
      curTag  = qTag.pop_front();
      if (curMask != 32'd0) begin
        checks++;
        if ((statusWord & curMask) != (curVal & curMask)) begin
          errors++;
          $display("FAIL %s actual=%08h expected=%08h mask=%08h",
                   curTag, statusWord, curVal, curMask);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] ALL = 32'hFFFF_FFFF;

  initial begin
    @(negedge clk);
    cyc(ALL, 32'h04, "R2 reset value");
    rstN = 1'b1;
    cyc(ALL, 32'h14, "R1 R2 layout after reset");
    // exit from off into capture
    capState = 2'd1;
    cyc(ALL, 32'h10, "R5 exit clears");
    memEmpty = 1'b0; memWordWr = 1'b1;
    cyc(ALL, 32'h00, "R12 empty follows memory");
    memWordWr = 1'b0; traceValid = 1'b1; traceId = 7'h7C;
    cyc(ALL, 32'h00, "R7 non-reserved ID no trigger");
    traceId = 7'h7D;
    cyc(ALL, 32'h02, "R7 reserved ID triggers");
    traceValid = 1'b0;
    cyc(ALL, 32'h02, "R10 triggered sticky");
    memFull = 1'b1;
    cyc(ALL, 32'h03, "R11 full sets");
    memFull = 1'b0;
    cyc(ALL, 32'h03, "R11 full sticky");
    // stopping: idle conditions
    capState = 2'd2; pipeDrained = 1'b0;
    cyc(ALL, 32'h03, "R3 not drained");
    pipeDrained = 1'b1; drainActive = 1'b1;
    cyc(ALL, 32'h0B, "R4 ftempty ignores drain");
    drainActive = 1'b0; busIdle = 1'b0;
    cyc(ALL, 32'h0B, "R3 bus busy blocks ready");
    busIdle = 1'b1; writeRespDone = 1'b0;
    cyc(ALL, 32'h0B, "R3 response pending blocks ready");
    writeRespDone = 1'b1;
    cyc(ALL, 32'h0F, "R3 ready when all idle");
    // off: hold, full ignores memory changes
    capState = 2'd0; pipeDrained = 1'b0; memFull = 1'b0; memEmpty = 1'b0;
    cyc(ALL, 32'h0F, "R6 hold in off");
    memFull = 1'b1;
    cyc(ALL, 32'h0F, "R11 off ignores memFull");
    memFull = 1'b0;
    cyc(ALL, 32'h0F, "R6 R11 hold in off");
    // exit again, pin trigger with count 3
    capState = 2'd1; memEmpty = 1'b1; pipeDrained = 1'b1;
    cyc(ALL, 32'h10, "R5 second exit clears");
    trigIn = 1'b1; memWordWr = 1'b1;
    cyc(32'h2, 32'h0, "R8 rise arms");
    cyc(32'h2, 32'h0, "R8 count 3 to 2");
    trigIn = 1'b0; memWordWr = 1'b0;
    cyc(32'h2, 32'h0, "R8 no write holds");
    trigIn = 1'b1; memWordWr = 1'b1;
    cyc(32'h2, 32'h0, "R9 second rise ignored");
    trigIn = 1'b0;
    cyc(32'h2, 32'h0, "R8 count reaches zero");
    memWordWr = 1'b0;
    cyc(32'h2, 32'h2, "R8 R9 triggered after count");
    capState = 2'd0;
    cyc(32'h2, 32'h2, "R6 triggered held in off");
    capState = 2'd1; postTrigCount = 16'd0;
    cyc(32'h2, 32'h0, "R5 exit clears triggered");
    trigIn = 1'b1;
    cyc(32'h2, 32'h0, "R8 zero count arms");
    trigIn = 1'b0;
    cyc(32'h2, 32'h2, "R8 zero count fires next cycle");
    // triggers outside capture are ignored
    capState = 2'd0;
    cyc(32'h0, 32'h0, "idle");
    capState = 2'd2;
    cyc(32'h2, 32'h0, "R5 exit into stopping clears");
    trigIn = 1'b1; traceValid = 1'b1; traceId = 7'h7D;
    cyc(32'h0E, 32'h0C, "R10 no trigger while stopping");
    trigIn = 1'b0; traceValid = 1'b0;
    cyc(32'h2, 32'h0, "R10 still not triggered");
    cyc(32'h0, 32'h0, "drain");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule